// File: doc/BRIEF.md
# Interrupting 32-Line GPIO Bank

This block is one bank of general-purpose I/O lines behind a simple register bus. Software sets per-line direction, output values, a blink enable and an input inversion. It reads back a synchronized, polarity-corrected image of the pins. Each line can raise an interrupt on its level, on a latched edge, or both. The lines are OR-merged in groups of eight onto four summary interrupt wires that go to the system interrupt controller.

Each pin passes through a two-flop synchronizer. It is then XORed with its polarity bit. The corrected value drives both the data-in view and the edge detector, so one rising-edge latch serves either edge direction. A latched edge stays pending until software writes a zero to that cause bit. A line in output mode with blink enabled drives its output bit ANDed with a slow square wave. The wave is generated inside the block.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output, blink, polarity, edge-cause, edge-mask and level-mask registers read zero. The direction register reads all ones, so every line is an input, `pinOe` is zero and `irqSummary` is zero.
- R2: The registers sit at fixed byte offsets: output value 0x00, direction 0x04, blink enable 0x08, polarity 0x0C, data-in 0x10, edge cause 0x14, edge mask 0x18, level mask 0x1C. Bit i of each register belongs to line i. A value written to a writable register reads back unchanged through `busRdata`, which is combinational from `busAddr`.
- R3: A direction bit of 1 makes its line an input with `pinOe` low. A direction bit of 0 raises `pinOe` for that line, and `pinOut` carries the output-value bit.
- R4: Data-in bit i equals pin i after two clock edges of synchronization, XOR polarity bit i. The new value is readable after the second rising clock edge following the pin change.
- R5: An edge-cause bit sets when its polarity-corrected input goes from 0 to 1. This is one clock edge after the change appears in data-in. The bit stays set after the input returns. With polarity 1 the bit records a falling pin edge.
- R6: A write to the edge-cause offset clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R7: A line's interrupt is (data-in AND level mask) OR (edge cause AND edge mask). Summary output k is the OR of the interrupts of lines 8k to 8k+7.
- R8: A line with its blink bit set drives its output bit ANDed with a free-running square wave that spends `BLINK_HALF` clocks high and `BLINK_HALF` clocks low. A line without blink drives its output bit steadily.
- R9: Reads of any offset outside the map return zero. A write to the data-in offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Value driven toward the pins |
| pinOe | output | 32 | Per-line output enable |
| irqSummary | output | 4 | One interrupt per group of eight lines |

## Verification
The bench builds the block with 32 lines, groups of eight and `BLINK_HALF` set to 3. With that setting, several full blink periods fit in a short window. Counting high samples over whole periods then gives an exact figure whatever the wave's phase. The default group size lets single lines be placed in each of the four summary groups, so a test can show that each summary output responds only to its own group.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int OFF_OUT        = 'h00;
  localparam int OFF_DIR        = 'h04;
  localparam int OFF_BLINK      = 'h08;
  localparam int OFF_POL        = 'h0C;
  localparam int OFF_DATAIN     = 'h10;
  localparam int OFF_CAUSE      = 'h14;
  localparam int OFF_EDGE_MASK  = 'h18;
  localparam int OFF_LEVEL_MASK = 'h1C;

  typedef enum logic [3:0] {
    SEL_OUT, SEL_DIR, SEL_BLINK, SEL_POL, SEL_DATAIN,
    SEL_CAUSE, SEL_EDGE_MASK, SEL_LEVEL_MASK, SEL_NONE
  } rdsel_t;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrBlink;
    logic wrPol;
    logic wrCause;
    logic wrEdgeMask;
    logic wrLevelMask;
    logic blinkPhase;
  } strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BLINK_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           stb,
  output rdsel_t            rdSel
);
  localparam int CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

  logic [CNT_W-1:0] blinkCnt;
  logic             blinkWave;
  logic             blinkWrap;

  assign blinkWrap = (blinkCnt == CNT_W'(BLINK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blinkCnt  <= '0;
      blinkWave <= 1'b0;
    end else if (blinkWrap) begin
      blinkCnt  <= '0;
      blinkWave <= ~blinkWave;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFF_OUT):        rdSel = SEL_OUT;
      ADDR_W'(OFF_DIR):        rdSel = SEL_DIR;
      ADDR_W'(OFF_BLINK):      rdSel = SEL_BLINK;
      ADDR_W'(OFF_POL):        rdSel = SEL_POL;
      ADDR_W'(OFF_DATAIN):     rdSel = SEL_DATAIN;
      ADDR_W'(OFF_CAUSE):      rdSel = SEL_CAUSE;
      ADDR_W'(OFF_EDGE_MASK):  rdSel = SEL_EDGE_MASK;
      ADDR_W'(OFF_LEVEL_MASK): rdSel = SEL_LEVEL_MASK;
      default:                 rdSel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb             = '0;
    stb.wrOut       = busWe && (rdSel == SEL_OUT);
    stb.wrDir       = busWe && (rdSel == SEL_DIR);
    stb.wrBlink     = busWe && (rdSel == SEL_BLINK);
    stb.wrPol       = busWe && (rdSel == SEL_POL);
    stb.wrCause     = busWe && (rdSel == SEL_CAUSE);
    stb.wrEdgeMask  = busWe && (rdSel == SEL_EDGE_MASK);
    stb.wrLevelMask = busWe && (rdSel == SEL_LEVEL_MASK);
    stb.blinkPhase  = blinkWave;
  end

  // R9: a bus write to the data-in offset raises no write strobe
  p_datain_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_W'(OFF_DATAIN)) |->
      ($countones({stb.wrOut, stb.wrDir, stb.wrBlink, stb.wrPol,
                   stb.wrCause, stb.wrEdgeMask, stb.wrLevelMask}) == 0));

  // R2: at most one register is written per bus cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrOut, stb.wrDir, stb.wrBlink, stb.wrPol,
              stb.wrCause, stb.wrEdgeMask, stb.wrLevelMask}));

  // R8: the blink wave only turns over after a full half period
  p_blink_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blinkWave) |-> ($past(blinkCnt) == CNT_W'(BLINK_HALF - 1)));
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int LINES   = 32,
  parameter int GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            stb,
  input  rdsel_t             rdSel,
  input  logic [LINES-1:0]   busWdata,
  output logic [LINES-1:0]   busRdata,
  input  logic [LINES-1:0]   pinIn,
  output logic [LINES-1:0]   pinOut,
  output logic [LINES-1:0]   pinOe,
  output logic [LINES/GROUP_W-1:0] irqSummary
);
  localparam int GROUPS = LINES / GROUP_W;

  logic [LINES-1:0] outVal, dirIn, blinkEn, polInv;
  logic [LINES-1:0] edgeCause, edgeMask, levelMask;
  logic [LINES-1:0] syncA, syncB, prevAdj;
  logic [LINES-1:0] adjIn, riseHit, lineIrq, blinkGate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA   <= '0;
      syncB   <= '0;
      prevAdj <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevAdj <= adjIn;
    end
  end

  assign adjIn   = syncB ^ polInv;
  assign riseHit = adjIn & ~prevAdj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outVal    <= '0;
      dirIn     <= '1;
      blinkEn   <= '0;
      polInv    <= '0;
      edgeMask  <= '0;
      levelMask <= '0;
      edgeCause <= '0;
    end else begin
      if (stb.wrOut)       outVal    <= busWdata;
      if (stb.wrDir)       dirIn     <= busWdata;
      if (stb.wrBlink)     blinkEn   <= busWdata;
      if (stb.wrPol)       polInv    <= busWdata;
      if (stb.wrEdgeMask)  edgeMask  <= busWdata;
      if (stb.wrLevelMask) levelMask <= busWdata;
      edgeCause <= (edgeCause & (stb.wrCause ? busWdata : '1)) | riseHit;
    end
  end

  assign lineIrq   = (adjIn & levelMask) | (edgeCause & edgeMask);
  assign blinkGate = blinkEn & {LINES{~stb.blinkPhase}};
  assign pinOut    = outVal & ~blinkGate;
  assign pinOe     = ~dirIn;

  for (genvar g = 0; g < GROUPS; g++) begin : g_summary
    assign irqSummary[g] = |lineIrq[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    unique case (rdSel)
      SEL_OUT:        busRdata = outVal;
      SEL_DIR:        busRdata = dirIn;
      SEL_BLINK:      busRdata = blinkEn;
      SEL_POL:        busRdata = polInv;
      SEL_DATAIN:     busRdata = adjIn;
      SEL_CAUSE:      busRdata = edgeCause;
      SEL_EDGE_MASK:  busRdata = edgeMask;
      SEL_LEVEL_MASK: busRdata = levelMask;
      default:        busRdata = '0;
    endcase
  end

  // R5: without a cause write, no pending edge bit is lost
  p_cause_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wrCause |=> ((edgeCause & $past(edgeCause)) == $past(edgeCause)));

  // R5: a rising corrected input is latched on the next edge
  p_rise_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (riseHit != '0) |=> ((edgeCause & $past(riseHit)) == $past(riseHit)));

  // R6: a cause write never clears a bit written as 1
  p_cause_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrCause |=>
      ((edgeCause & $past(edgeCause & busWdata)) == $past(edgeCause & busWdata)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int LINES      = 32,
  parameter int GROUP_W    = 8,
  parameter int ADDR_W     = 8,
  parameter int BLINK_HALF = 4,
  localparam int GROUPS    = LINES / GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [LINES-1:0]  busWdata,
  output logic [LINES-1:0]  busRdata,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic [GROUPS-1:0] irqSummary
);
  strobe_t stb;
  rdsel_t  rdSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W), .BLINK_HALF(BLINK_HALF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .stb(stb), .rdSel(rdSel)
  );

  gpio_bank_datapath #(.LINES(LINES), .GROUP_W(GROUP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rdSel(rdSel),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqSummary(irqSummary)
  );
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic [3:0]  irqSummary;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.LINES(32), .GROUP_W(8), .ADDR_W(8), .BLINK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqSummary(irqSummary)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 out", v, 32'h0);
    rd(8'h04, v); check("R1 dir", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 cause", v, 32'h0);
    rd(8'h18, v); check("R1 edge mask", v, 32'h0);
    rd(8'h1C, v); check("R1 level mask", v, 32'h0);
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 irq", {28'h0, irqSummary}, 32'h0);
  endtask

  task automatic test_regmap();
    logic [31:0] v;
    wr(8'h08, 32'h1234_5678); rd(8'h08, v); check("R2 blink readback", v, 32'h1234_5678);
    wr(8'h18, 32'hCAFE_0001); rd(8'h18, v); check("R2 edge mask readback", v, 32'hCAFE_0001);
    wr(8'h1C, 32'h0F0F_00F0); rd(8'h1C, v); check("R2 level mask readback", v, 32'h0F0F_00F0);
    wr(8'h08, 32'h0); wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
  endtask

  task automatic test_direction();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_0000);
    wr(8'h00, 32'h0000_A5A5);
    rd(8'h04, v); check("R2 dir readback", v, 32'hFFFF_0000);
    check("R3 pinOe", pinOe, 32'h0000_FFFF);
    check("R3 pinOut", pinOut, 32'h0000_A5A5);
  endtask

  task automatic test_datain();
    logic [31:0] v;
    wr(8'h0C, 32'h0000_0030);
    @(negedge clk); pinIn = 32'h0000_00F0;
    tick(1); rd(8'h10, v); check("R4 not yet through sync", v, 32'h0000_0030);
    tick(1); rd(8'h10, v); check("R4 data-in xor polarity", v, 32'h0000_00C0);
    pinIn = 32'h0; wr(8'h0C, 32'h0); tick(3);
    wr(8'h14, 32'h0);
  endtask

  task automatic test_edge();
    logic [31:0] v;
    @(negedge clk); pinIn[5] = 1'b1;
    tick(2); rd(8'h14, v); check("R5 cause not before edge latch", v, 32'h0);
    tick(1); rd(8'h14, v); check("R5 rising edge latched", v, 32'h0000_0020);
    pinIn[5] = 1'b0; tick(4);
    rd(8'h14, v); check("R5 cause sticky", v, 32'h0000_0020);
    wr(8'h0C, 32'h0000_0200); tick(3);
    wr(8'h14, 32'hFFFF_FDFF);
    rd(8'h14, v); check("R6 clear only zero-written bit", v, 32'h0000_0020);
    pinIn[9] = 1'b1; tick(4);
    rd(8'h14, v); check("R5 pin rise with polarity ignored", v, 32'h0000_0020);
    pinIn[9] = 1'b0; tick(4);
    rd(8'h14, v); check("R5 falling edge via polarity", v, 32'h0000_0220);
    wr(8'h14, 32'h0);
    rd(8'h14, v); check("R6 write zero clears all", v, 32'h0);
    wr(8'h0C, 32'h0); tick(3); wr(8'h14, 32'h0);
  endtask

  task automatic test_summary();
    logic [31:0] v;
    wr(8'h1C, 32'h0000_1000);
    @(negedge clk); pinIn[12] = 1'b1; tick(2);
    check("R7 level irq group 1", {28'h0, irqSummary}, 32'h2);
    wr(8'h14, 32'h0);
    @(negedge clk); pinIn[30] = 1'b1; tick(3);
    check("R7 edge unmasked no irq", {28'h0, irqSummary}, 32'h2);
    wr(8'h18, 32'h4000_0000);
    check("R7 edge irq group 3", {28'h0, irqSummary}, 32'hA);
    wr(8'h1C, 32'h0);
    check("R7 level mask removes group 1", {28'h0, irqSummary}, 32'h8);
    wr(8'h14, 32'h0);
    check("R7 cleared cause drops group 3", {28'h0, irqSummary}, 32'h0);
    rd(8'h14, v); check("R6 cause cleared", v, 32'h0);
    wr(8'h18, 32'h0); pinIn = 32'h0; tick(3); wr(8'h14, 32'h0);
  endtask

  task automatic test_blink();
    int ones = 0;
    int steady = 0;
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0000_0003);
    wr(8'h08, 32'h0000_0001);
    for (int i = 0; i < 4*HALF; i++) begin
      @(negedge clk);
      if (pinOut[0]) ones++;
      if (pinOut[1]) steady++;
    end
    check("R8 blink duty over two periods", ones, 2*HALF);
    check("R8 non-blink line steady", steady, 4*HALF);
    wr(8'h08, 32'h0);
    check("R8 blink off restores output", pinOut, 32'h0000_0003);
  endtask

  task automatic test_unmapped();
    logic [31:0] v;
    wr(8'h00, 32'h0000_5555);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R9 data-in write leaves out", v, 32'h0000_5555);
    rd(8'h04, v); check("R9 data-in write leaves dir", v, 32'h0);
    rd(8'h0C, v); check("R9 data-in write leaves polarity", v, 32'h0);
    rd(8'h10, v); check("R9 data-in still pin view", v, 32'h0);
    rd(8'h20, v); check("R9 unmapped 0x20", v, 32'h0);
    rd(8'h02, v); check("R9 unaligned offset", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    test_reset();
    test_regmap();
    test_direction();
    test_datain();
    test_edge();
    test_summary();
    test_blink();
    test_unmapped();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule